// File: doc/BRIEF.md
# Snoop Control Register Block

This block is the software-visible register file of a multi-core cluster's snoop control unit. It sits on a plain 32-bit register bus (address, read strobe, write strobe, write data, read data) and holds one control bit that enables snooping for the cluster. The bit is also driven out as a level for the rest of the cluster to use.

The block also returns a read-only configuration word that describes the cluster. The low nibble holds the core count minus one. Above it, starting at bit 4, is a mask with one set bit for each core that is present. A core status word always reads as zero. A cache invalidate-all command is accepted and has no effect.

Read data is registered: it appears on the bus one cycle after the read strobe and is zero in every other cycle. Any access the map does not allow produces a one-cycle error pulse in that same following cycle. This covers reads of unmapped offsets, and writes to read-only or unmapped offsets. The core count is a parameter from 1 to 4.

Top module: `snoop_ctl_regs`

## Requirements
- R1: After reset, the control bit, `snoop_en`, `bus_rdata` and `bus_err` are all zero.
- R2: A write to byte offset 0x00 stores only bit 0 of `bus_wdata`. The stored bit appears on `snoop_en` in the cycle after the write, and a read of offset 0x00 returns it zero-extended to 32 bits.
- R3: A read of offset 0x04 returns the configuration word. It has ((1<<N)-1)<<4 in bits [31:4] and N-1 in bits [3:0], where N is the core count.
- R4: Reads of offset 0x08 (core status) and offset 0x0C (invalidate-all) return zero without an error.
- R5: A write to offset 0x0C is accepted without an error and leaves the control bit unchanged.
- R6: A read of any offset other than 0x00, 0x04, 0x08 and 0x0C returns zero and raises `bus_err`. This includes offsets that are not word-aligned.
- R7: A write to offset 0x04, offset 0x08 or any unmapped offset leaves the control bit unchanged and raises `bus_err`.
- R8: `bus_rdata` is registered. It carries the read value in the cycle after a read strobe and is zero in any cycle that follows no read strobe.
- R9: `bus_err` is high for exactly the one cycle after an erroneous access and is low after any cycle with no disallowed access.
- R10: The core count parameter accepts values 1 to 4, and values outside that range stop elaboration.
- R11: When a read and a write of offset 0x00 occur in the same cycle, the read returns the value held before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | AW (8) | Byte offset of the access |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| bus_err | output | 1 | One-cycle error pulse after a disallowed access |
| snoop_en | output | 1 | Current value of the stored control bit |

## Verification
The bound checker tests properties of every cycle. It checks that the control bit follows a write to offset 0x00 and holds otherwise, and that idle cycles give zero read data and no error. It also checks the error pulse and zero data for bad reads, the configuration value on each read of 0x04, and the absence of an error on an invalidate write. The bench's sweeps over all 256 byte offsets, for reads and for writes, show the full address map in one small configuration. These include the misaligned offsets and the read-only locations. Only the bench's directed sequences can show the value order of a combined read and write of the control offset, the encodings for several core counts, and that a single error pulse is followed by a quiet cycle.

// File: rtl/snoop_regs_pkg.sv
package snoop_regs_pkg;

  localparam int unsigned DW = 32;

  // Byte offsets decoded by the block; the address map is behaviour.
  localparam int unsigned OFS_CTRL  = 'h00;
  localparam int unsigned OFS_CFG   = 'h04;
  localparam int unsigned OFS_STAT  = 'h08;
  localparam int unsigned OFS_INVAL = 'h0C;

  // One-hot view of the decoded location.
  typedef struct packed {
    logic ctrl;
    logic cfg;
    logic stat;
    logic inval;
  } reg_hit_t;

  // Configuration word: presence mask from bit 4 up, count minus one below.
  function automatic logic [DW-1:0] cfg_word(input int unsigned ncores);
    logic [DW-1:0] w;
    w = '0;
    for (int unsigned i = 0; i < ncores; i++) begin
      w[4+i] = 1'b1;
    end
    w[3:0] = 4'(ncores - 1);
    return w;
  endfunction

  // A read is legal at any of the four mapped locations.
  function automatic logic read_legal(input reg_hit_t h);
    return h.ctrl | h.cfg | h.stat | h.inval;
  endfunction

  // A write is legal only where something can be written or accepted.
  function automatic logic write_legal(input reg_hit_t h);
    return h.ctrl | h.inval;
  endfunction

endpackage

// File: rtl/snoop_addr_decode.sv
module snoop_addr_decode
  import snoop_regs_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic [AW-1:0] addr,
  output reg_hit_t      hit
);

  localparam logic [AW-1:0] A_CTRL  = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_CFG   = AW'(OFS_CFG);
  localparam logic [AW-1:0] A_STAT  = AW'(OFS_STAT);
  localparam logic [AW-1:0] A_INVAL = AW'(OFS_INVAL);

  // Full compare: misaligned offsets match nothing.
  always_comb begin
    hit.ctrl  = (addr == A_CTRL);
    hit.cfg   = (addr == A_CFG);
    hit.stat  = (addr == A_STAT);
    hit.inval = (addr == A_INVAL);
  end

endmodule

// File: rtl/snoop_ctrl_bit.sv
module snoop_ctrl_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic d,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (we) begin
      q <= d;
    end
  end

endmodule

// File: rtl/snoop_read_path.sv
module snoop_read_path
  import snoop_regs_pkg::*;
#(
  parameter int unsigned CORES = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          rd_bad,
  input  logic          wr_bad,
  input  reg_hit_t      hit,
  input  logic          ctrl_q,
  output logic [DW-1:0] rdata,
  output logic          err
);

  localparam logic [DW-1:0] CFG_VALUE = cfg_word(CORES);

  logic [DW-1:0] rdata_d;

  // Status and invalidate locations fall through to zero.
  always_comb begin
    rdata_d = '0;
    if (rd) begin
      if (hit.ctrl) rdata_d = {{(DW-1){1'b0}}, ctrl_q};
      if (hit.cfg)  rdata_d = CFG_VALUE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      rdata <= rdata_d;
      err   <= rd_bad | wr_bad;
    end
  end

endmodule

// File: rtl/snoop_ctl_regs.sv
module snoop_ctl_regs
  import snoop_regs_pkg::*;
#(
  parameter int unsigned CORES = 4,
  parameter int unsigned AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_err,
  output logic          snoop_en
);

  generate
    if (CORES < 1 || CORES > 4) begin : g_bad_cores
      $error("snoop_ctl_regs: CORES must be 1..4");
    end
    if (AW < 4) begin : g_bad_aw
      $error("snoop_ctl_regs: AW must be at least 4");
    end
  endgenerate

  reg_hit_t hit;
  logic     ctrl_we;
  logic     rd_bad;
  logic     wr_bad;
  logic     unused_wdata;

  snoop_addr_decode #(.AW(AW)) u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  // Named events for the checker.
  assign ctrl_we = bus_wr & hit.ctrl;
  assign rd_bad  = bus_rd & ~read_legal(hit);
  assign wr_bad  = bus_wr & ~write_legal(hit);

  // Only bit 0 of write data is kept.
  assign unused_wdata = ^bus_wdata[31:1];

  snoop_ctrl_bit u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctrl_we),
    .d     (bus_wdata[0]),
    .q     (snoop_en)
  );

  snoop_read_path #(.CORES(CORES)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (bus_rd),
    .rd_bad (rd_bad),
    .wr_bad (wr_bad),
    .hit    (hit),
    .ctrl_q (snoop_en),
    .rdata  (bus_rdata),
    .err    (bus_err)
  );

endmodule

// File: rtl/snoop_regs_chk.sv
module snoop_regs_chk #(
  parameter int unsigned CORES = 4,
  parameter int unsigned AW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [31:0]   bus_wdata,
  input logic [31:0]   bus_rdata,
  input logic          bus_err,
  input logic          snoop_en,
  input logic          rd_bad,
  input logic          wr_bad
);

  // Expected configuration by arithmetic, independent of the package loop.
  localparam logic [31:0] CFG_EXP = 32'(((1 << CORES) - 1) * 16 + (CORES - 1));

  logic is_ctrl;
  logic is_cfg;
  logic is_inval;
  assign is_ctrl  = (bus_addr == AW'(0));
  assign is_cfg   = (bus_addr == AW'(4));
  assign is_inval = (bus_addr == AW'(12));

  // R2
  a_r2_ctrl_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_ctrl) |=> (snoop_en == $past(bus_wdata[0])));

  // R5 and R7
  a_r7_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && is_ctrl) |=> $stable(snoop_en));

  // R3
  a_r3_cfg_value: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && is_cfg) |=> (bus_rdata == CFG_EXP));

  // R5
  a_r5_inval_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && is_inval && !bus_rd) |=> !bus_err);

  // R6
  a_r6_bad_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bad |=> (bus_err && bus_rdata == 32'd0));

  // R7
  a_r7_bad_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |=> bus_err);

  // R8
  a_r8_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == 32'd0));

  // R9
  a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !bus_wr) |=> !bus_err);

endmodule

bind snoop_ctl_regs snoop_regs_chk #(.CORES(CORES), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_err   (bus_err),
  .snoop_en  (snoop_en),
  .rd_bad    (rd_bad),
  .wr_bad    (wr_bad)
);

// File: tb/sim_snoop_ctl_regs.sv
`timescale 1ns/1ps
module sim_snoop_ctl_regs;

  localparam int unsigned N0 = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata0, rdata1, rdata4;
  logic        err0, err1, err4;
  logic        en0, en1, en4;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  snoop_ctl_regs #(.CORES(N0), .AW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata0), .bus_err(err0), .snoop_en(en0));

  snoop_ctl_regs #(.CORES(1), .AW(8)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata1), .bus_err(err1), .snoop_en(en1));

  snoop_ctl_regs #(.CORES(4), .AW(8)) u4 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata4), .bus_err(err4), .snoop_en(en4));

  function automatic logic [31:0] exp_cfg(input int n);
    return (((32'd1 << n) - 32'd1) << 4) | 32'(n - 1);
  endfunction

  function automatic bit rd_ok(input int a);
    return (a == 0) || (a == 4) || (a == 8) || (a == 12);
  endfunction

  function automatic bit wr_ok(input int a);
    return (a == 0) || (a == 12);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with strobes cleared.
  task automatic access(input logic rd, input logic wr, input int a, input logic [31:0] d);
    bus_rd = rd; bus_wr = wr; bus_addr = 8'(a); bus_wdata = d;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    logic ctrl_exp;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata0, 32'd0);
    check("R1 err", {31'd0, err0}, 32'd0);
    check("R1 snoop_en", {31'd0, en0}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 snoop_en after release", {31'd0, en0}, 32'd0);
    ctrl_exp = 1'b0;

    // R2 control write with wide data keeps only bit 0
    access(1'b0, 1'b1, 0, 32'hFFFF_FFFF);
    ctrl_exp = 1'b1;
    check("R2 snoop_en set", {31'd0, en0}, 32'd1);
    check("R2 no err", {31'd0, err0}, 32'd0);
    access(1'b1, 1'b0, 0, 32'd0);
    check("R2 read ctrl zero-extended", rdata0, 32'd1);
    access(1'b0, 1'b1, 0, 32'hFFFF_FFFE);
    ctrl_exp = 1'b0;
    access(1'b1, 1'b0, 0, 32'd0);
    check("R2 read ctrl cleared", rdata0, 32'd0);

    // R11 simultaneous read and write of control
    access(1'b0, 1'b1, 0, 32'd1);
    access(1'b1, 1'b1, 0, 32'd0);
    check("R11 read returns old value", rdata0, 32'd1);
    check("R11 write takes effect", {31'd0, en0}, 32'd0);
    ctrl_exp = 1'b0;

    // R3 / R10 configuration for three core counts
    access(1'b1, 1'b0, 4, 32'd0);
    check("R3 cfg N=3", rdata0, exp_cfg(N0));
    check("R10 cfg N=1", rdata1, exp_cfg(1));
    check("R10 cfg N=4", rdata4, exp_cfg(4));
    // R8 data is zero in the cycle after, with no read
    @(negedge clk);
    check("R8 rdata idle", rdata0, 32'd0);
    check("R9 err quiet", {31'd0, err0}, 32'd0);

    // Read sweep over every byte offset: R4, R6, R8
    for (int a = 0; a < 256; a++) begin
      logic [31:0] e;
      e = (a == 0) ? {31'd0, ctrl_exp} : (a == 4) ? exp_cfg(N0) : 32'd0;
      access(1'b1, 1'b0, a, 32'd0);
      check(rd_ok(a) ? "R4 read mapped" : "R6 read unmapped", rdata0, e);
      check(rd_ok(a) ? "R4 no err" : "R6 err pulse", {31'd0, err0}, {31'd0, !rd_ok(a)});
    end

    // Write sweep over every byte offset: R5, R7, R9
    for (int a = 0; a < 256; a++) begin
      logic nb;
      nb = ~ctrl_exp;
      access(1'b0, 1'b1, a, {31'h2AAA_5555, nb});
      if (a == 0) ctrl_exp = nb;
      check(wr_ok(a) ? "R5 ctrl after write" : "R7 ctrl ignored", {31'd0, en0}, {31'd0, ctrl_exp});
      check(wr_ok(a) ? "R5 no err" : "R7 err pulse", {31'd0, err0}, {31'd0, !wr_ok(a)});
      if (!wr_ok(a) && (a % 16 == 3)) begin
        @(negedge clk);
        check("R9 err single cycle", {31'd0, err0}, 32'd0);
      end
    end

    // R5 invalidate write then read back control through the bus
    access(1'b0, 1'b1, 12, 32'd1);
    access(1'b1, 1'b0, 0, 32'd0);
    check("R5 ctrl read after invalidate", rdata0, {31'd0, ctrl_exp});

    done = 1'b1;
    finish_run();
  end

endmodule